// File: doc/BRIEF.md
# SPI Register-Access Master with Indirect Read-Back

This block is a serial master that reads and writes the registers of an external filter-control device. A user-side request carries a read/write flag, a 5-bit register address and a 24-bit data word. The block turns a write into one 32-bit frame and a read into two frames with a chip-select release between them. When the request is finished it returns a one-cycle completion pulse, an error flag and, for a read, 24 bits of data.

Every frame holds 32 bits and is sent most significant bit first. The 24-bit data word comes first, then a command byte that holds the register address and a fixed 3-bit device tag. A read is indirect. The first frame writes the wanted address, as a data word, into register 0. The second frame shifts out zeros and captures the device's reply. The serial clock idles low. On writes the master moves its data on the falling edge, so the device captures it on the rising edge. On the reply frame the master samples on the falling edge. The device keeps driving its output while deselected, so the master takes no bits outside a selected frame.

Top module: `spi_regacc_master`

## Requirements
- R1: A frame is exactly 32 serial clock pulses with chip select low. Bits go most significant first: data word bits [31:8], then the command byte bits [7:0].
- R2: The command byte is {address[4:0], 3'b101}. The address occupies bits [7:3] and the tag 3'b101 occupies bits [2:0].
- R3: The serial clock is low whenever chip select is high. MOSI changes only on falling edges, so it is steady while the clock is high.
- R4: A read sends a write frame to register 0 whose data word is the address, zero-extended to 24 bits. A second frame of 32 zero bits follows, sampled on falling edges. The returned data is the first 24 bits received.
- R5: The error flag is raised, together with the completion pulse of a read, when bits [2:0] of the last received byte differ from 3'b101. The error flag is never high without the completion pulse.
- R6: Chip select is high for at least 2 system clock cycles between any two frames, including between the two frames of a read.
- R7: MISO has no effect on the result while chip select is high.
- R8: One serial clock period lasts 8 system clock cycles.
- R9: A request is taken only when valid and ready are both high. Ready is low from acceptance until the request completes, and a request presented while busy starts no frame.
- R10: Completion is one single-cycle pulse. For a write it follows the single frame. For a read it follows the second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 5 | Target register address |
| req_wdata | input | 24 | Data word for a write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Reply tag mismatch, valid with rsp_done |
| rsp_rdata | output | 24 | Data of the last completed read |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Device data in |

## Verification
The properties assume the requester follows the valid/ready rule. A request is counted only in a cycle where ready is high. The properties also assume reset is held long enough for the registers to settle. The stimulus drives every request field at the falling clock edge and holds it until ready has been seen. It also deliberately holds valid high while the block is busy, which exercises that rule without breaking it. The device model drives random noise on MISO whenever it is deselected and changes its reply bits only just after rising serial clock edges, so any sampling on the wrong edge or outside the frame shows up as wrong data.

// File: rtl/spi_regacc_pkg.sv
`timescale 1ns/1ps
package spi_regacc_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 24;
  localparam int ADDR_W  = 5;
  localparam int TAG_W   = 3;
  localparam logic [TAG_W-1:0] DEV_TAG = 3'b101;

  typedef enum logic [2:0] {
    S_IDLE, S_XFER, S_GAP, S_RECV, S_FIN
  } seq_state_t;

  // Outgoing word: data first, then {address, tag}
  function automatic logic [FRAME_W-1:0] make_frame(logic [DATA_W-1:0] d,
                                                    logic [ADDR_W-1:0] a);
    return {d, a, DEV_TAG};
  endfunction

  function automatic logic tag_ok(logic [FRAME_W-1:0] rx);
    return rx[TAG_W-1:0] == DEV_TAG;
  endfunction

  function automatic logic [DATA_W-1:0] rx_payload(logic [FRAME_W-1:0] rx);
    return rx[FRAME_W-1 -: DATA_W];
  endfunction
endpackage

// File: rtl/spi_regacc_clkgen.sv
`timescale 1ns/1ps
module spi_regacc_clkgen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q;

  assign rise_tick = run && (cnt_q == CW'(HALF - 1));
  assign fall_tick = run && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else begin
      cnt_q <= fall_tick ? '0 : cnt_q + 1'b1;
      if (rise_tick)      sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_regacc_shifter.sv
`timescale 1ns/1ps
module spi_regacc_shifter
  import spi_regacc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               fall_tick,
  input  logic               miso,
  output logic               active,
  output logic               mosi,
  output logic               frame_end,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int BW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] tx_q;
  logic [BW-1:0]      bit_q;

  assign frame_end = active && fall_tick && (bit_q == BW'(FRAME_W - 1));
  assign mosi      = active && tx_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      tx_q    <= '0;
      rx_word <= '0;
      bit_q   <= '0;
    end else if (start) begin
      active <= 1'b1;
      tx_q   <= load_word;
      bit_q  <= '0;
    end else if (active && fall_tick) begin
      tx_q    <= {tx_q[FRAME_W-2:0], 1'b0};
      rx_word <= {rx_word[FRAME_W-2:0], miso};
      bit_q   <= bit_q + 1'b1;
      if (frame_end) active <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_regacc_seq.sv
`timescale 1ns/1ps
module spi_regacc_seq
  import spi_regacc_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_rd,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               frame_end,
  input  logic [FRAME_W-1:0] rx_word,
  output logic               start,
  output logic [FRAME_W-1:0] load_word,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata
);
  localparam int GW = $clog2(GAP_CYC + 1);

  seq_state_t    state_q;
  logic          is_rd_q;
  logic [GW-1:0] gap_q;
  logic          gap_clear, accept;

  assign gap_clear = (gap_q == '0);
  assign req_ready = (state_q == S_IDLE) && gap_clear;
  assign accept    = req_valid && req_ready;
  assign start     = accept || ((state_q == S_GAP) && gap_clear);

  always_comb begin
    load_word = '0;
    if (state_q == S_IDLE)
      load_word = req_rd ? make_frame(DATA_W'(req_addr), ADDR_W'(0))
                         : make_frame(req_wdata, req_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      is_rd_q   <= 1'b0;
      gap_q     <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (frame_end)       gap_q <= GW'(GAP_CYC);
      else if (!gap_clear) gap_q <= gap_q - 1'b1;

      rsp_done <= ((state_q == S_XFER) && frame_end && !is_rd_q) || (state_q == S_FIN);
      rsp_err  <= (state_q == S_FIN) && !tag_ok(rx_word);
      if (state_q == S_FIN) rsp_rdata <= rx_payload(rx_word);

      unique case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_XFER;
          is_rd_q <= req_rd;
        end
        S_XFER: if (frame_end) state_q <= is_rd_q ? S_GAP : S_IDLE;
        S_GAP:  if (gap_clear) state_q <= S_RECV;
        S_RECV: if (frame_end) state_q <= S_FIN;
        S_FIN:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_regacc_master.sv
`timescale 1ns/1ps
module spi_regacc_master
  import spi_regacc_pkg::*;
#(
  parameter int SCLK_DIV = 8,
  parameter int GAP_CYC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_rd,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  input  logic               spi_miso
);
  // Internal events, named for the checker
  logic               frame_active;
  logic               rise_tick, fall_tick, frame_end, frame_start;
  logic [FRAME_W-1:0] load_word, rx_word;

  assign spi_cs_n = !frame_active;

  spi_regacc_clkgen #(.DIV(SCLK_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(frame_active),
    .sclk(spi_sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  spi_regacc_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .load_word(load_word),
    .fall_tick(fall_tick), .miso(spi_miso), .active(frame_active),
    .mosi(spi_mosi), .frame_end(frame_end), .rx_word(rx_word)
  );

  spi_regacc_seq #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .frame_end(frame_end), .rx_word(rx_word), .start(frame_start),
    .load_word(load_word), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/spi_regacc_master_chk.sv
`timescale 1ns/1ps
module spi_regacc_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic rsp_err,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic rise_tick,
  input logic fall_tick,
  input logic frame_end
);
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  p_frame_end_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> spi_cs_n);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_rise_from_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (!spi_sclk ##1 spi_sclk));

  p_fall_from_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (spi_sclk ##1 !spi_sclk));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_err_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind spi_regacc_master spi_regacc_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .rise_tick(rise_tick),
  .fall_tick(fall_tick), .frame_end(frame_end)
);

// File: tb/test_spi_regacc_master.sv
`timescale 1ns/1ps
module test_spi_regacc_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_rd = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic        req_ready, rsp_done, rsp_err;
  logic [23:0] rsp_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  spi_regacc_master i_spi_regacc_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  function automatic logic [23:0] init_val(int i);
    return 24'(i * 40503 + 24'h3C0007);
  endfunction

  // Device model state
  logic [23:0] dev_regs [32];
  logic [23:0] exp_regs [32];
  logic [4:0]  dev_ptr = '0;
  logic [31:0] dev_shift = '0, dev_resp = '0, last_frame = '0;
  int          dev_bits = 0, last_bits = 0, frames_seen = 0;
  bit          in_frame = 0, prev_sclk = 0, bad_tag = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          last_rise = 0, per_min = 1000, per_max = 0, gap_run = 0, gap_min = 1000;

  initial for (int i = 0; i < 32; i++) begin
    dev_regs[i] = init_val(i);
    exp_regs[i] = init_val(i);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    prev_sclk <= spi_sclk;
    if (spi_cs_n) begin
      spi_miso <= lfsr[0];  // noise while deselected
      if (in_frame) begin
        in_frame <= 0;
        frames_seen <= frames_seen + 1;
        last_frame <= dev_shift;
        last_bits <= dev_bits;
        gap_run <= 1;
        if (dev_bits == 32 && dev_shift[2:0] == 3'b101) begin
          if (dev_shift[7:3] == 5'd0) dev_ptr <= dev_shift[12:8];
          else dev_regs[dev_shift[7:3]] <= dev_shift[31:8];
        end
      end else gap_run <= gap_run + 1;
    end else begin
      if (!in_frame) begin
        in_frame <= 1;
        dev_bits <= 0;
        dev_resp <= {dev_regs[dev_ptr], dev_ptr, bad_tag ? 3'b011 : 3'b101};
        if (frames_seen > 0 && gap_run < gap_min) gap_min <= gap_run;
      end else if (spi_sclk && !prev_sclk) begin
        dev_shift <= {dev_shift[30:0], spi_mosi};
        spi_miso <= dev_resp[5'(31 - dev_bits)];
        dev_bits <= dev_bits + 1;
        if (dev_bits > 0) begin
          if (cyc - last_rise < per_min) per_min <= cyc - last_rise;
          if (cyc - last_rise > per_max) per_max <= cyc - last_rise;
        end
        last_rise <= cyc;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(bit rd, logic [4:0] a, logic [23:0] d);
    @(negedge clk);
    req_rd = rd; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit err, output logic [23:0] rd);
    int t = 0;
    while (!rsp_done && t < 3000) begin @(negedge clk); t++; end
    check("R10 completion seen", 32'(rsp_done), 32'd1);
    err = rsp_err; rd = rsp_rdata;
    @(negedge clk);
    check("R10 single-cycle done", 32'(rsp_done), 32'd0);
  endtask

  task automatic t_reset;
    check("R3 sclk idle low", 32'(spi_sclk), 32'd0);
    check("R6 cs_n high at rest", 32'(spi_cs_n), 32'd1);
    check("R9 ready after reset", 32'(req_ready), 32'd1);
    check("R10 no done at rest", 32'(rsp_done), 32'd0);
  endtask

  task automatic t_write(logic [4:0] a, logic [23:0] d);
    bit e; logic [23:0] r; int f0 = frames_seen;
    issue(0, a, d);
    wait_done(e, r);
    exp_regs[a] = d;
    check("R1 frame length", 32'(last_bits), 32'd32);
    check("R1 R2 frame content", last_frame, {d, a, 3'b101});
    check("R10 write uses one frame", 32'(frames_seen - f0), 32'd1);
    check("R2 device register updated", 32'(dev_regs[a]), 32'(exp_regs[a]));
    check("R5 write reports no error", 32'(e), 32'd0);
  endtask

  task automatic t_read(logic [4:0] a, string tag);
    bit e; logic [23:0] r; int f0 = frames_seen;
    issue(1, a, 24'h0);
    wait_done(e, r);
    check({tag, " read data"}, 32'(r), 32'(exp_regs[a]));
    check("R4 read uses two frames", 32'(frames_seen - f0), 32'd2);
    check("R4 second frame all zero", last_frame, 32'h0);
    check("R4 pointer written via register 0", 32'(dev_ptr), 32'(a));
    check("R5 good tag no error", 32'(e), 32'd0);
  endtask

  task automatic t_bad_tag;
    bit e; logic [23:0] r;
    bad_tag = 1;
    issue(1, 5'd9, 24'h0);
    wait_done(e, r);
    check("R5 tag mismatch raises error", 32'(e), 32'd1);
    bad_tag = 0;
  endtask

  task automatic t_busy;
    bit e; logic [23:0] r; int f0 = frames_seen;
    issue(0, 5'd4, 24'h123456);
    repeat (5) @(negedge clk);
    req_rd = 0; req_addr = 5'd6; req_wdata = 24'hDEAD00; req_valid = 1'b1;
    repeat (20) begin
      @(negedge clk);
      check("R9 ready low while busy", 32'(req_ready), 32'd0);
    end
    req_valid = 1'b0;
    wait_done(e, r);
    exp_regs[4] = 24'h123456;
    repeat (20) @(negedge clk);
    check("R9 busy request started no frame", 32'(frames_seen - f0), 32'd1);
    check("R9 untouched register", 32'(dev_regs[6]), 32'(exp_regs[6]));
  endtask

  task automatic t_timing;
    check("R8 min sclk period", 32'(per_min), 32'd8);
    check("R8 max sclk period", 32'(per_max), 32'd8);
    check("R6 chip select gap >= 2", 32'(gap_min >= 2), 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(5'd3, 24'hA1B2C3);
    t_write(5'd31, 24'hFFFFFF);
    t_write(5'd17, 24'h000000);
    t_read(5'd3, "R4");
    t_read(5'd31, "R4 R7 noise");
    t_read(5'd17, "R7");
    t_read(5'd22, "R4 unwritten");
    t_bad_tag();
    t_busy();
    t_read(5'd4, "R9 R4");
    t_timing();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule